// File: doc/BRIEF.md
# NAND Flash Command Interpreter

This block is the control core of a NAND flash device model. It is driven by already-latched bus strobes: a command byte, an address byte, a write-data byte, or a read-enable pulse. It decodes these into page loads, column moves and page programming. It keeps the column pointer into the page buffer and a flag that records whether data has been loaded since the last load-open command. It also times the busy periods from parameter cycle counts and decides which commands are honoured while the device is busy.

The page buffer and the cell array sit outside the block. The interpreter drives the buffer with a column index and read or write strobes, and receives the buffer byte back for output. It tells the array, with one-cycle strobes and a row address, when to fill the buffer and when to commit it. When the array commits a page, it returns a fail flag that the interpreter captures. The status byte replaces buffer data on the output once a status request is made, and it stays there until another command is accepted.

Top module: `nand_cmd_interp`

## Requirements
- R1: The sequence 00h, five address bytes, 30h pulses `arr_load_o` for one cycle, with `arr_row_o` = {addr5, addr4, addr3} (the last address byte is the most significant). It then holds `rdy_o` low for exactly T_LOAD cycles, after which read data mode is entered at column {addr2, addr1}.
- R2: In read data mode, each `re_i` pulse reads the byte at `buf_col_o` and then advances the pointer by one. The pointer stops at column PAGE_BYTES-1, so further pulses repeat that column. A column value above PAGE_BYTES-1 is clamped to it.
- R3: In read data mode, five address bytes followed by 30h start a new page load without a leading 00h.
- R4: The sequence 05h, two address bytes, E0h, given in read data mode, moves the read pointer to {addr2, addr1}. It may be repeated any number of times.
- R5: The sequence 80h followed by five address bytes opens a load at column {addr2, addr1}. Each `data_we_i` then pulses `buf_wr_o` with `buf_wdata_o` = `io_i` at `buf_col_o`, and advances the column. The sequence 85h, two address bytes moves the load column.
- R6: The 10h command pulses `arr_prog_o` with the load row and holds `rdy_o` low for exactly T_PROG cycles, but only if at least one data byte was written since 80h. Otherwise 10h is ignored and the load stays open.
- R7: While `rdy_o` is low, only 70h and FFh take effect. Other commands, address bytes, data bytes and read pulses are ignored.
- R8: After 70h, `dout_o` shows the status byte, and read pulses neither strobe the buffer nor move the pointer. This holds until another command is accepted.
- R9: The status byte is {1'b0, ready, 5'b0, fail}: bit 6 is 1 when ready, and bit 0 holds `prog_fail_i` as sampled at the end of the last program.
- R10: Read and load sequences take exactly five address bytes, and column moves take exactly two. Extra address bytes are ignored. A command arriving before the count completes abandons the sequence and is then decoded as if the interpreter were idle.
- R11: FFh, accepted in any state, aborts the current operation. It holds `rdy_o` low for T_RST cycles counted from its own edge, clears the load flag and the fail bit, and leaves the interpreter idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | `io_i` carries a command byte this cycle |
| addr_we_i | input | 1 | `io_i` carries an address byte this cycle |
| data_we_i | input | 1 | `io_i` carries a data byte to load this cycle |
| re_i | input | 1 | Read pulse, one per output byte |
| io_i | input | 8 | Command, address or data byte |
| buf_rdata_i | input | 8 | Page buffer byte at `buf_col_o` |
| prog_fail_i | input | 1 | Array reports program failure, sampled when programming ends |
| rdy_o | output | 1 | Ready (1) or busy (0) |
| dout_o | output | 8 | Status byte in status mode, buffer byte otherwise |
| buf_col_o | output | COL_W | Current page buffer column |
| buf_rd_o | output | 1 | Buffer read strobe |
| buf_wr_o | output | 1 | Buffer write strobe |
| buf_wdata_o | output | 8 | Buffer write byte |
| arr_load_o | output | 1 | One-cycle request to fill the buffer from the array |
| arr_prog_o | output | 1 | One-cycle request to program the buffer into the array |
| arr_row_o | output | 24 | Row address for load or program |

## Verification
A wrong column pointer appears on `buf_col_o` at once, and in the data returned by the very next read pulse. A wrong sequence state appears on the first strobe that should or should not follow it: a missing `buf_wr_o`, a stray `arr_load_o`, or `rdy_o` falling when it should not. Busy-length errors show as a count of low `rdy_o` cycles that differs from T_LOAD, T_PROG or T_RST. Errors in status mode show on `dout_o` on the next read, as a status byte where data was expected, or the reverse.

// File: rtl/nand_ci_pkg.sv
package nand_ci_pkg;
  localparam logic [7:0] CMD_READ    = 8'h00;
  localparam logic [7:0] CMD_READ_GO = 8'h30;
  localparam logic [7:0] CMD_RCOL    = 8'h05;
  localparam logic [7:0] CMD_RCOL_GO = 8'hE0;
  localparam logic [7:0] CMD_LOAD    = 8'h80;
  localparam logic [7:0] CMD_LCOL    = 8'h85;
  localparam logic [7:0] CMD_PROG_GO = 8'h10;
  localparam logic [7:0] CMD_STATUS  = 8'h70;
  localparam logic [7:0] CMD_RESET   = 8'hFF;

  localparam int unsigned FULL_ADDR_CYC = 5;
  localparam int unsigned COL_ADDR_CYC  = 2;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RD_ADDR, ST_RD_CFM, ST_RD_DATA, ST_RC_ADDR, ST_RC_CFM,
    ST_PG_ADDR, ST_PG_DATA, ST_PC_ADDR, ST_BUSY
  } state_e;

  typedef enum logic [1:0] {OP_LOAD, OP_PROG, OP_RST} op_e;
endpackage

// File: rtl/nand_ci_addr.sv
module nand_ci_addr
  import nand_ci_pkg::*;
#(
  parameter int unsigned COL_W    = 12,
  parameter int unsigned LAST_COL = 2111
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             short_i,
  input  logic             we_i,
  input  logic [7:0]       byte_i,
  output logic             done_o,
  output logic [COL_W-1:0] col_o,
  output logic [23:0]      row_o
);
  localparam int unsigned BYTES_W = FULL_ADDR_CYC * 8;

  logic [BYTES_W-1:0] bytes_q;
  logic [2:0]         cnt_q, need_q;
  logic               wr_en;
  logic [2:0]         wr_idx;
  logic [15:0]        raw_col;

  assign wr_en  = start_i ? we_i : (we_i && cnt_q < need_q);
  assign wr_idx = start_i ? 3'd0 : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      need_q  <= '0;
      bytes_q <= '0;
    end else begin
      if (start_i) begin
        need_q <= short_i ? 3'(COL_ADDR_CYC) : 3'(FULL_ADDR_CYC);
        cnt_q  <= we_i ? 3'd1 : 3'd0;
      end else if (wr_en) begin
        cnt_q <= cnt_q + 3'd1;
      end
      for (int i = 0; i < FULL_ADDR_CYC; i++) begin
        if (wr_en && wr_idx == 3'(i)) bytes_q[i*8 +: 8] <= byte_i;
      end
    end
  end

  assign done_o  = (need_q != 3'd0) && (cnt_q == need_q);
  assign raw_col = bytes_q[15:0];
  assign col_o   = (raw_col > 16'(LAST_COL)) ? COL_W'(LAST_COL) : raw_col[COL_W-1:0];
  assign row_o   = bytes_q[39:16];

  // extra address bytes past the count leave the captured address alone
  assert_extra_addr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && we_i && !start_i) |=> ($stable(col_o) && $stable(row_o)));
endmodule

// File: rtl/nand_ci_timer.sv
module nand_ci_timer #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             busy_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_o <= 1'b1;
      cnt_q  <= len_i;
    end else if (busy_o) begin
      if (cnt_q == '0) busy_o <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign done_o = busy_o && (cnt_q == '0);

  assert_busy_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
endmodule

// File: rtl/nand_cmd_interp.sv
module nand_cmd_interp
  import nand_ci_pkg::*;
#(
  parameter int unsigned PAGE_BYTES = 2112,
  parameter int unsigned T_LOAD     = 20,
  parameter int unsigned T_PROG     = 40,
  parameter int unsigned T_RST      = 5,
  localparam int unsigned COL_W     = $clog2(PAGE_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_we_i,
  input  logic             addr_we_i,
  input  logic             data_we_i,
  input  logic             re_i,
  input  logic [7:0]       io_i,
  input  logic [7:0]       buf_rdata_i,
  input  logic             prog_fail_i,
  output logic             rdy_o,
  output logic [7:0]       dout_o,
  output logic [COL_W-1:0] buf_col_o,
  output logic             buf_rd_o,
  output logic             buf_wr_o,
  output logic [7:0]       buf_wdata_o,
  output logic             arr_load_o,
  output logic             arr_prog_o,
  output logic [23:0]      arr_row_o
);
  localparam int unsigned LAST_COL = PAGE_BYTES - 1;
  localparam int unsigned MAX_T = (T_PROG > T_LOAD) ? ((T_PROG > T_RST) ? T_PROG : T_RST)
                                                    : ((T_LOAD > T_RST) ? T_LOAD : T_RST);
  localparam int unsigned TMR_W = $clog2(MAX_T + 1);

  state_e state_q, state_n, cur, base;
  op_e    op_q, op_n;
  logic [COL_W-1:0] col_q, col_n, cur_col;
  logic stat_q, stat_n, vld_q, vld_n, fail_q, fail_n;
  logic load_p, prog_p, a_wait;
  logic a_start, a_short, a_we, a_done;
  logic [COL_W-1:0] a_col;
  logic [23:0] a_row;
  logic t_start, t_busy, t_done;
  logic [TMR_W-1:0] t_len;

  function automatic logic [COL_W-1:0] col_inc(input logic [COL_W-1:0] c);
    return (c == COL_W'(LAST_COL)) ? c : c + 1'b1;
  endfunction

  assign a_we = addr_we_i && !cmd_we_i && !t_busy;

  nand_ci_addr #(.COL_W(COL_W), .LAST_COL(LAST_COL)) i_addr (
    .clk_i, .rst_ni, .start_i(a_start), .short_i(a_short), .we_i(a_we),
    .byte_i(io_i), .done_o(a_done), .col_o(a_col), .row_o(a_row));

  nand_ci_timer #(.CNT_W(TMR_W)) i_timer (
    .clk_i, .rst_ni, .start_i(t_start), .len_i(t_len), .busy_o(t_busy), .done_o(t_done));

  // view of the state once a just-completed address phase is taken into account
  always_comb begin
    cur = state_q; cur_col = col_q; a_wait = 1'b0;
    case (state_q)
      ST_RD_ADDR: if (a_done) cur = ST_RD_CFM; else a_wait = 1'b1;
      ST_RC_ADDR: if (a_done) cur = ST_RC_CFM; else a_wait = 1'b1;
      ST_PG_ADDR, ST_PC_ADDR:
        if (a_done) begin cur = ST_PG_DATA; cur_col = a_col; end
        else a_wait = 1'b1;
      default: ;
    endcase
    base = a_wait ? ST_IDLE : cur;
  end

  always_comb begin
    state_n = cur; col_n = cur_col; op_n = op_q;
    stat_n = stat_q; vld_n = vld_q; fail_n = fail_q;
    t_start = 1'b0; t_len = TMR_W'(T_RST - 1);
    a_start = 1'b0; a_short = 1'b0; load_p = 1'b0; prog_p = 1'b0;
    buf_rd_o = 1'b0; buf_wr_o = 1'b0;
    if (t_done) begin
      case (op_q)
        OP_LOAD: state_n = ST_RD_DATA;
        OP_PROG: begin state_n = ST_IDLE; fail_n = prog_fail_i; end
        default: state_n = ST_IDLE;
      endcase
    end
    if (cmd_we_i) begin
      if (t_busy) begin
        if (io_i == CMD_STATUS) stat_n = 1'b1;
      end else begin
        if (a_wait) state_n = ST_IDLE;
        case (io_i)
          CMD_READ: begin state_n = ST_RD_ADDR; a_start = 1'b1; stat_n = 1'b0; end
          CMD_READ_GO: if (base == ST_RD_CFM) begin
            state_n = ST_BUSY; op_n = OP_LOAD; t_start = 1'b1; t_len = TMR_W'(T_LOAD - 1);
            load_p = 1'b1; col_n = a_col; stat_n = 1'b0;
          end
          CMD_RCOL: if (base == ST_RD_DATA) begin
            state_n = ST_RC_ADDR; a_start = 1'b1; a_short = 1'b1; stat_n = 1'b0;
          end
          CMD_RCOL_GO: if (base == ST_RC_CFM) begin
            state_n = ST_RD_DATA; col_n = a_col; stat_n = 1'b0;
          end
          CMD_LOAD: begin
            state_n = ST_PG_ADDR; a_start = 1'b1; vld_n = 1'b0; stat_n = 1'b0;
          end
          CMD_LCOL: if (base == ST_PG_DATA) begin
            state_n = ST_PC_ADDR; a_start = 1'b1; a_short = 1'b1; stat_n = 1'b0;
          end
          CMD_PROG_GO: if (base == ST_PG_DATA && vld_q) begin
            state_n = ST_BUSY; op_n = OP_PROG; t_start = 1'b1; t_len = TMR_W'(T_PROG - 1);
            prog_p = 1'b1; stat_n = 1'b0;
          end
          CMD_STATUS: stat_n = 1'b1;
          default: ;
        endcase
      end
      if (io_i == CMD_RESET) begin
        state_n = ST_BUSY; op_n = OP_RST; t_start = 1'b1; t_len = TMR_W'(T_RST - 1);
        stat_n = 1'b0; vld_n = 1'b0; fail_n = 1'b0;
      end
    end else if (addr_we_i) begin
      if (!t_busy && cur == ST_RD_DATA) begin state_n = ST_RD_ADDR; a_start = 1'b1; end
    end else if (data_we_i) begin
      if (!t_busy && cur == ST_PG_DATA) begin
        buf_wr_o = 1'b1; vld_n = 1'b1; col_n = col_inc(cur_col);
      end
    end else if (re_i) begin
      if (!t_busy && !stat_q && cur == ST_RD_DATA) begin
        buf_rd_o = 1'b1; col_n = col_inc(cur_col);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE; op_q <= OP_RST; col_q <= '0;
      stat_q <= 1'b0; vld_q <= 1'b0; fail_q <= 1'b0;
      arr_load_o <= 1'b0; arr_prog_o <= 1'b0; arr_row_o <= '0;
    end else begin
      state_q <= state_n; op_q <= op_n; col_q <= col_n;
      stat_q <= stat_n; vld_q <= vld_n; fail_q <= fail_n;
      arr_load_o <= load_p; arr_prog_o <= prog_p;
      if (load_p || prog_p) arr_row_o <= a_row;
    end
  end

  assign rdy_o       = !t_busy;
  assign dout_o      = stat_q ? {1'b0, !t_busy, 5'b0, fail_q} : buf_rdata_i;
  assign buf_col_o   = cur_col;
  assign buf_wdata_o = io_i;

  assert_busy_src_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rdy_o) |-> $past(cmd_we_i));
  assert_col_max_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_q <= COL_W'(LAST_COL));
  assert_prog_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_prog_o |-> $past(cmd_we_i && io_i == CMD_PROG_GO && vld_q));
  assert_stat_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stat_q) |-> $past(cmd_we_i));
  assert_busy_ignore_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (t_busy && !t_done && cmd_we_i && io_i != CMD_STATUS && io_i != CMD_RESET)
      |=> (state_q == ST_BUSY && $stable(col_q)));
endmodule

// File: tb/test_nand_cmd_interp.sv
module test_nand_cmd_interp;
  localparam int PAGE = 2112;
  localparam int LAST = PAGE - 1;
  localparam int TL = 20, TP = 40, TR = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_we = 0, addr_we = 0, data_we = 0, re = 0, pfail = 0;
  logic [7:0] io = 0, brd, dout, wdata;
  logic rdy, brd_s, bwr_s, ld, pg;
  logic [11:0] bcol;
  logic [23:0] row;
  int n_chk = 0, n_fail = 0, busy_n = 0;

  always #4 clk = ~clk;
  always @(posedge clk) if (!rdy) busy_n <= busy_n + 1;

  function automatic logic [7:0] bval(input int c);
    return 8'(c) ^ {4'(c >> 8), 4'h3};
  endfunction
  assign brd = bval(int'(bcol));

  nand_cmd_interp #(.PAGE_BYTES(PAGE), .T_LOAD(TL), .T_PROG(TP), .T_RST(TR)) i_nand_cmd_interp (
    .clk_i(clk), .rst_ni(rst_n), .cmd_we_i(cmd_we), .addr_we_i(addr_we), .data_we_i(data_we),
    .re_i(re), .io_i(io), .buf_rdata_i(brd), .prog_fail_i(pfail), .rdy_o(rdy), .dout_o(dout),
    .buf_col_o(bcol), .buf_rd_o(brd_s), .buf_wr_o(bwr_s), .buf_wdata_o(wdata),
    .arr_load_o(ld), .arr_prog_o(pg), .arr_row_o(row));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [7:0] b);
    io = b; cmd_we = 1; @(negedge clk); cmd_we = 0;
  endtask
  task automatic adr(input logic [7:0] b);
    io = b; addr_we = 1; @(negedge clk); addr_we = 0;
  endtask
  task automatic wr(input logic [7:0] b, input int c, input string req);
    io = b; data_we = 1; #1;
    chk(bwr_s === 1'b1 && wdata === b && int'(bcol) == c, req, {bwr_s, wdata, 4'(0), bcol}, {1'b1, b, 4'(0), 12'(c)});
    @(negedge clk); data_we = 0;
  endtask
  task automatic rd_pulse(output logic s);
    re = 1; #1; s = brd_s; @(negedge clk); re = 0;
  endtask
  task automatic wait_rdy();
    while (!rdy) @(negedge clk);
  endtask
  task automatic addr5(input int c, input logic [23:0] r);
    adr(8'(c)); adr(8'(c >> 8)); adr(r[7:0]); adr(r[15:8]); adr(r[23:16]);
  endtask
  task automatic read_run(input int c0, input int n, input string req);
    int c = c0;
    logic s;
    for (int i = 0; i < n; i++) begin
      chk(int'(bcol) == c && dout === bval(c), req, bcol, c);
      rd_pulse(s);
      chk(s === 1'b1, req, s, 1);
      c = (c < LAST) ? c + 1 : LAST;
    end
  endtask
  task automatic page_load(input int c, input logic [23:0] r, input bit with_00, input string req);
    if (with_00) cmd(8'h00);
    addr5(c, r);
    busy_n = 0;
    cmd(8'h30);
    chk(ld === 1'b1 && row === r, req, row, r);
    wait_rdy();
    chk(busy_n == TL, req, busy_n, TL);
  endtask
  task automatic col_move(input int c);
    cmd(8'h05); adr(8'(c)); adr(8'(c >> 8)); cmd(8'hE0);
  endtask

  initial begin
    int c;
    logic [23:0] r;
    logic s;
    void'($urandom(32'd31));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(rdy === 1'b1 && ld === 1'b0 && pg === 1'b0, "R11 reset state", rdy, 1);
    cmd(8'h70);
    chk(dout === 8'h40, "R9 idle status", dout, 8'h40);

    // R1 / R2 read flow
    c = int'($urandom_range(0, LAST - 20)); r = 24'($urandom);
    page_load(c, r, 1, "R1");
    chk(int'(bcol) == c, "R1 start column", bcol, c);
    read_run(c, int'($urandom_range(3, 8)), "R2");

    // R4 repeated column moves
    for (int k = 0; k < 3; k++) begin
      c = int'($urandom_range(0, LAST));
      col_move(c);
      read_run(c, 2, "R4");
    end
    // R2 end of page and clamping
    col_move(LAST - 2);
    read_run(LAST - 2, 5, "R2 end of page");
    col_move(16'hFFFF);
    chk(int'(bcol) == LAST, "R2 clamp", bcol, LAST);

    // R3 load without leading 00h
    c = int'($urandom_range(0, 1000)); r = 24'($urandom);
    page_load(c, r, 0, "R3");
    read_run(c, 2, "R3");

    // R8 status mode holds
    c = int'(bcol);
    cmd(8'h70);
    for (int k = 0; k < 3; k++) begin
      chk(dout === 8'h40, "R8 status data", dout, 8'h40);
      rd_pulse(s);
      chk(s === 1'b0 && int'(bcol) == c, "R8 no pointer move", bcol, c);
    end
    col_move(100);
    chk(dout === bval(100), "R8 status cleared", dout, bval(100));

    // R10 cancel and extra address
    cmd(8'h00); adr(8'h01); adr(8'h00); adr(8'h07);
    busy_n = 0;
    cmd(8'h30); @(negedge clk);
    chk(rdy === 1'b1 && busy_n == 0 && ld === 1'b0, "R10 short sequence cancelled", busy_n, 0);
    cmd(8'h00); adr(8'h11); adr(8'h22);
    cmd(8'h80);
    c = int'($urandom_range(0, 1500)); r = 24'($urandom);
    addr5(c, r); adr(8'hAB);
    wr(8'h5C, c, "R10 extra address ignored");

    // R5 data load and load column move
    for (int k = 1; k < 5; k++) wr(8'($urandom), c + k, "R5 data load");
    c = int'($urandom_range(0, LAST));
    cmd(8'h85); adr(8'(c)); adr(8'(c >> 8));
    wr(8'($urandom), c, "R5 load column move");

    // R6 program, R7 busy filtering
    busy_n = 0;
    cmd(8'h10);
    chk(pg === 1'b1 && row === r, "R6 program strobe", row, r);
    cmd(8'h00); cmd(8'h80);
    wr_ignored: begin
      io = 8'h99; data_we = 1; #1;
      chk(bwr_s === 1'b0, "R7 data ignored when busy", bwr_s, 0);
      @(negedge clk); data_we = 0;
    end
    cmd(8'h70);
    chk(dout === 8'h00, "R9 busy status", dout, 8'h00);
    wait_rdy();
    chk(busy_n == TP, "R6 program time", busy_n, TP);
    chk(dout === 8'h40, "R9 status after program", dout, 8'h40);
    io = 8'h42; data_we = 1; #1;
    chk(bwr_s === 1'b0, "R7 80h ignored while busy", bwr_s, 0);
    @(negedge clk); data_we = 0;

    // R6 confirm with no data
    cmd(8'h80); c = 40; addr5(c, 24'h000123);
    busy_n = 0;
    cmd(8'h10); @(negedge clk);
    chk(rdy === 1'b1 && busy_n == 0 && pg === 1'b0, "R6 empty confirm ignored", busy_n, 0);
    wr(8'h77, c, "R6 load still open");
    pfail = 1;
    cmd(8'h10);
    wait_rdy();
    pfail = 0;
    cmd(8'h70);
    chk(dout === 8'h41, "R9 fail bit", dout, 8'h41);

    // R11 reset during load
    page_load_abort: begin
      cmd(8'h00); addr5(10, 24'h000456); cmd(8'h30);
      @(negedge clk); @(negedge clk);
      busy_n = 0;
      cmd(8'hFF);
      wait_rdy();
      chk(busy_n == TR + 1, "R11 reset busy time", busy_n, TR + 1);
      rd_pulse(s);
      chk(s === 1'b0, "R11 idle after reset", s, 0);
      cmd(8'h70);
      chk(dout === 8'h40, "R11 fail cleared", dout, 8'h40);
    end

    // random read sequences
    for (int k = 0; k < 6; k++) begin
      c = int'($urandom_range(0, LAST)); r = 24'($urandom);
      page_load(c, r, 1, "R1 random");
      read_run(c, int'($urandom_range(1, 6)), "R2 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule